// File: doc/BRIEF.md
# Audio Splice-Point Finder

After a read interruption, a player re-reads audio from the disc and has to resume buffering exactly behind the last samples it had confirmed. This block finds that point. It keeps the last six confirmed 16-bit words, which form three left/right pairs. It then watches the freshly re-read stereo stream until the newest three pairs agree with that reference. When they do, it raises a one-cycle connect pulse so the encoder can resume writing at the valid write address.

A two-bit command selects one of three ways to connect. Strict mode needs all three pairs to agree. Majority mode accepts two of the three. Direct mode makes no comparison and connects after a fixed number of words. The same command field also stops a search. An optional coarse comparison ignores the low bits of every word. The reference is loaded only through a separate capture strobe. Encoding, buffer addressing and the memory are handled elsewhere.

Top module: `splice_seq`

## Requirements
- R1: A command with `cmd_mode` 2'b11 (strict), 2'b10 (majority) or 2'b01 (direct) sets `busy` in the cycle after it is sampled, and a start issued while `busy` restarts the search with an empty window.
- R2: In strict mode, `connect` rises in the cycle after the right word that completes a pair, when the newest three completed pairs, oldest first, equal reference pairs 0, 1 and 2. The window slides by one pair with each completed pair.
- R3: In majority mode the same evaluation connects when at least two of the three pair positions agree. One agreeing position does not connect.
- R4: In direct mode no comparison is made, and `connect` rises in the cycle after the third sample word accepted since the start.
- R5: With `coarse_cmp` high, bits 3:0 of every word are ignored in comparisons. The input is read at each evaluation, so changing it during a search affects words already held.
- R6: The first strict or majority start after reset discards the first 5 accepted sample words before pairing begins. Later starts skip this preparation.
- R7: A pair is a left word (`smp_right`=0) followed by a right word (`smp_right`=1). A right word with no pending left word is ignored, and a newer left word replaces a pending one.
- R8: `cmd_mode` 2'b00 with `cmd_encode` low clears `busy` in the next cycle without a connect pulse. It has no effect when the block is idle.
- R9: `cmd_encode` is ignored when it comes with a start code. With code 2'b00 while `busy`, it forces an immediate connect in the next cycle. While idle it does nothing.
- R10: `connect` lasts exactly one cycle and falls together with `busy`. The reference is the last six words presented on `cap_word` with `cap_valid` high: the oldest is pair 0 left and the newest is pair 2 right. A capture in the same cycle as an evaluation affects only later evaluations.
- R11: A sample word presented in the same cycle as any command is discarded.
- R12: After reset, `busy` and `connect` are low and the reference words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_mode | input | 2 | 11 strict, 10 majority, 01 direct, 00 stop |
| cmd_encode | input | 1 | Encoder resume request sent with the command |
| smp_valid | input | 1 | Re-read sample word present |
| smp_right | input | 1 | Sample is the right channel |
| smp_word | input | 16 | Sample word |
| cap_valid | input | 1 | Capture strobe for the reference |
| cap_word | input | 16 | Confirmed word to capture |
| coarse_cmp | input | 1 | Ignore the low 4 bits in comparisons |
| busy | output | 1 | Search in progress |
| connect | output | 1 | One-cycle splice pulse |

## Verification
Two functions can fall in the same cycle: a command and the right word that would complete a matching pair, and a reference capture and a pair evaluation. The bench presents a restart together with the final matching right word and expects no pulse and an emptied window. It also strobes a capture together with a final word and expects the connect decision to use the old reference. A behavioural queue model, updated on every edge, judges both collisions, along with the encode-request collisions of R9.

// File: rtl/splice_pkg.sv
package splice_pkg;

  typedef enum logic [1:0] {
    MODE_STOP   = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_MAJOR  = 2'b10,
    MODE_STRICT = 2'b11
  } splice_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_CMP,
    ST_DIR
  } splice_state_e;

  // Bits kept in a comparison: the word's width, minus the low bits when coarse.
  function automatic logic [31:0] keep_mask(int width, int drop, logic coarse);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) begin
      m[i] = (i < width) && (!coarse || (i >= drop));
    end
    return m;
  endfunction

  function automatic logic words_agree(logic [31:0] a, logic [31:0] b, logic [31:0] keep);
    return ((a ^ b) & keep) == 32'd0;
  endfunction

  // Acceptance rule: all positions in strict mode, a quorum otherwise.
  function automatic logic verdict(int hits, logic strict, int all_n, int some_n);
    return strict ? (hits >= all_n) : (hits >= some_n);
  endfunction

endpackage

// File: rtl/splice_refbank.sv
module splice_refbank #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_en,
  input  logic [WORD_W-1:0]             cap_word,
  output logic [WORDS-1:0][WORD_W-1:0]  ref_words
);

  // Index 0 holds the oldest captured word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_words <= '0;
    end else if (cap_en) begin
      for (int i = 0; i < WORDS - 1; i++) begin
        ref_words[i] <= ref_words[i+1];
      end
      ref_words[WORDS-1] <= cap_word;
    end
  end

endmodule

// File: rtl/splice_window.sv
module splice_window #(
  parameter int WORD_W = 16,
  parameter int PAIRS  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          take,
  input  logic                          is_right,
  input  logic [WORD_W-1:0]             word,
  output logic [PAIRS-1:0][WORD_W-1:0]  cand_l,
  output logic [PAIRS-1:0][WORD_W-1:0]  cand_r,
  output logic                          cand_full,
  output logic                          pair_done
);

  localparam int KEEP   = PAIRS - 1;
  localparam int FILL_W = $clog2(KEEP + 1);
  localparam logic [FILL_W-1:0] FILL_NEED = FILL_W'(KEEP);

  logic [WORD_W-1:0]           hold_l;
  logic                        have_l;
  logic [FILL_W-1:0]           fill;
  logic [KEEP-1:0][WORD_W-1:0] win_l;
  logic [KEEP-1:0][WORD_W-1:0] win_r;

  assign pair_done = take && is_right && have_l;
  assign cand_full = (fill == FILL_NEED);

  // Candidate = stored pairs (oldest first) followed by the pair completing now.
  for (genvar gi = 0; gi < KEEP; gi++) begin : g_cand
    assign cand_l[gi] = win_l[gi];
    assign cand_r[gi] = win_r[gi];
  end
  assign cand_l[PAIRS-1] = hold_l;
  assign cand_r[PAIRS-1] = word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      have_l <= 1'b0;
      fill   <= '0;
      win_l  <= '0;
      win_r  <= '0;
    end else if (clr) begin
      have_l <= 1'b0;
      fill   <= '0;
    end else if (take) begin
      if (!is_right) begin
        hold_l <= word;
        have_l <= 1'b1;
      end else if (have_l) begin
        for (int i = 0; i < KEEP - 1; i++) begin
          win_l[i] <= win_l[i+1];
          win_r[i] <= win_r[i+1];
        end
        win_l[KEEP-1] <= hold_l;
        win_r[KEEP-1] <= word;
        have_l        <= 1'b0;
        if (fill != FILL_NEED) fill <= fill + 1'b1;
      end
    end
  end

endmodule

// File: rtl/splice_ctrl.sv
module splice_ctrl
  import splice_pkg::*;
#(
  parameter int PREP_WORDS   = 5,
  parameter int DIRECT_WORDS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_mode,
  input  logic       cmd_encode,
  input  logic       word_valid,
  input  logic       pair_done,
  input  logic       pair_hit,
  output logic       busy,
  output logic       connect,
  output logic       win_clr,
  output logic       win_take,
  output logic       strict_mode,
  output logic       in_prep
);

  localparam int PREP_CW = $clog2(PREP_WORDS + 1);
  localparam int DIR_CW  = $clog2(DIRECT_WORDS + 1);
  localparam logic [PREP_CW-1:0] PREP_LAST = PREP_CW'(PREP_WORDS - 1);
  localparam logic [DIR_CW-1:0]  DIR_LAST  = DIR_CW'(DIRECT_WORDS - 1);

  splice_state_e      state;
  logic               warm;
  logic [PREP_CW-1:0] prep_cnt;
  logic [DIR_CW-1:0]  dir_cnt;

  logic ev_start, ev_stop, ev_splice, word_take;

  always_comb begin
    ev_start  = cmd_valid && (cmd_mode != MODE_STOP);
    ev_stop   = cmd_valid && (cmd_mode == MODE_STOP) && !cmd_encode;
    ev_splice = cmd_valid && (cmd_mode == MODE_STOP) && cmd_encode && busy;
    word_take = word_valid && !cmd_valid && busy;
    win_take  = word_take && (state == ST_CMP);
    win_clr   = ev_start;
  end

  assign busy    = (state != ST_IDLE);
  assign in_prep = (state == ST_PREP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      warm        <= 1'b0;
      strict_mode <= 1'b0;
      prep_cnt    <= '0;
      dir_cnt     <= '0;
      connect     <= 1'b0;
    end else begin
      connect <= 1'b0;
      if (ev_start) begin
        strict_mode <= (cmd_mode == MODE_STRICT);
        prep_cnt    <= '0;
        dir_cnt     <= '0;
        if (cmd_mode == MODE_DIRECT) begin
          state <= ST_DIR;
        end else if (!warm) begin
          state <= ST_PREP;
          warm  <= 1'b1;
        end else begin
          state <= ST_CMP;
        end
      end else if (ev_splice) begin
        connect <= 1'b1;
        state   <= ST_IDLE;
      end else if (ev_stop) begin
        state <= ST_IDLE;
      end else if (word_take) begin
        unique case (state)
          ST_PREP: begin
            if (prep_cnt == PREP_LAST) state <= ST_CMP;
            else prep_cnt <= prep_cnt + 1'b1;
          end
          ST_CMP: begin
            if (pair_done && pair_hit) begin
              connect <= 1'b1;
              state   <= ST_IDLE;
            end
          end
          ST_DIR: begin
            if (dir_cnt == DIR_LAST) begin
              connect <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              dir_cnt <= dir_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/splice_seq.sv
module splice_seq
  import splice_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int DROP_BITS    = 4,
  parameter int PAIRS        = 3,
  parameter int QUORUM       = 2,
  parameter int PREP_WORDS   = 5,
  parameter int DIRECT_WORDS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_mode,
  input  logic              cmd_encode,
  input  logic              smp_valid,
  input  logic              smp_right,
  input  logic [WORD_W-1:0] smp_word,
  input  logic              cap_valid,
  input  logic [WORD_W-1:0] cap_word,
  input  logic              coarse_cmp,
  output logic              busy,
  output logic              connect
);

  localparam int REF_WORDS = 2 * PAIRS;
  localparam int HIT_W     = $clog2(PAIRS + 1);

  logic [REF_WORDS-1:0][WORD_W-1:0] ref_words;
  logic [PAIRS-1:0][WORD_W-1:0]     cand_l;
  logic [PAIRS-1:0][WORD_W-1:0]     cand_r;
  logic                             cand_full, pair_done, pair_hit;
  logic                             win_clr, win_take, strict_mode, in_prep;
  logic [PAIRS-1:0]                 pair_ok;
  logic [HIT_W-1:0]                 hit_count;
  logic [31:0]                      keep;

  splice_refbank #(.WORD_W(WORD_W), .WORDS(REF_WORDS)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_valid),
    .cap_word (cap_word),
    .ref_words(ref_words)
  );

  splice_window #(.WORD_W(WORD_W), .PAIRS(PAIRS)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (win_clr),
    .take     (win_take),
    .is_right (smp_right),
    .word     (smp_word),
    .cand_l   (cand_l),
    .cand_r   (cand_r),
    .cand_full(cand_full),
    .pair_done(pair_done)
  );

  splice_ctrl #(.PREP_WORDS(PREP_WORDS), .DIRECT_WORDS(DIRECT_WORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_mode   (cmd_mode),
    .cmd_encode (cmd_encode),
    .word_valid (smp_valid),
    .pair_done  (pair_done),
    .pair_hit   (pair_hit),
    .busy       (busy),
    .connect    (connect),
    .win_clr    (win_clr),
    .win_take   (win_take),
    .strict_mode(strict_mode),
    .in_prep    (in_prep)
  );

  assign keep = keep_mask(WORD_W, DROP_BITS, coarse_cmp);

  for (genvar gk = 0; gk < PAIRS; gk++) begin : g_cmp
    assign pair_ok[gk] = words_agree(32'(cand_l[gk]), 32'(ref_words[2*gk]), keep) &&
                         words_agree(32'(cand_r[gk]), 32'(ref_words[2*gk+1]), keep);
  end

  assign hit_count = HIT_W'($countones(pair_ok));
  assign pair_hit  = cand_full && verdict(int'(hit_count), strict_mode, PAIRS, QUORUM);

endmodule

// File: rtl/splice_seq_chk.sv
module splice_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_mode,
  input logic       cmd_encode,
  input logic       busy,
  input logic       connect,
  input logic       in_prep
);

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode != 2'b00) |=> (busy && !connect)) else $error("start"); // R1

  AST_PREP_NO_CONNECT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prep && !cmd_valid) |=> !connect) else $error("prep"); // R6

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == 2'b00 && !cmd_encode) |=> (!busy && !connect)) else $error("stop"); // R8

  AST_SPLICE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == 2'b00 && cmd_encode && busy) |=> connect) else $error("splice"); // R9

  AST_CONNECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    connect |=> !connect) else $error("pulse"); // R10

  AST_CONNECT_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    connect |-> !busy) else $error("busy with connect"); // R10

  AST_CONNECT_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    connect |-> $past(busy)) else $error("connect from idle"); // R10

endmodule

bind splice_seq splice_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_mode  (cmd_mode),
  .cmd_encode(cmd_encode),
  .busy      (busy),
  .connect   (connect),
  .in_prep   (in_prep)
);

// File: tb/test_splice_seq.sv
module test_splice_seq;

  localparam int CLK_T   = 10;
  localparam int PREP_N  = 5;
  localparam int DIRECT_N = 3;
  localparam int WATCHDOG = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_mode = 2'b00;
  logic        cmd_encode = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_right = 1'b0;
  logic [15:0] smp_word = '0;
  logic        cap_valid = 1'b0;
  logic [15:0] cap_word = '0;
  logic        coarse_cmp = 1'b0;
  logic        busy, connect;

  always #(CLK_T/2) clk = ~clk;

  splice_seq i_splice_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_encode(cmd_encode), .smp_valid(smp_valid), .smp_right(smp_right),
    .smp_word(smp_word), .cap_valid(cap_valid), .cap_word(cap_word),
    .coarse_cmp(coarse_cmp), .busy(busy), .connect(connect)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    conn_seen = 0;
  bit    done = 0;
  string cur_req = "R12";

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_state;   // 0 idle, 1 preparing, 2 comparing, 3 direct
  bit          m_warm, m_strict, m_has_l;
  int          m_prep, m_dir;
  logic [15:0] m_l;
  logic [31:0] m_pairs[$];
  logic [15:0] m_ref[$];
  bit          exp_busy, exp_conn;

  function automatic bit same(logic [15:0] a, logic [15:0] b);
    if (coarse_cmp) return (a >> 4) == (b >> 4);
    return a == b;
  endfunction

  function automatic bit accepts();
    int hits = 0;
    foreach (m_pairs[k])
      if (same(m_pairs[k][31:16], m_ref[2*k]) && same(m_pairs[k][15:0], m_ref[2*k+1])) hits++;
    return m_strict ? (hits == 3) : (hits >= 2);
  endfunction

  task automatic model_step();
    bit nc = 0;
    if (!rst_n) begin
      m_state = 0; m_warm = 0; m_strict = 0; m_has_l = 0; m_prep = 0; m_dir = 0;
      m_pairs.delete(); m_ref.delete();
      repeat (6) m_ref.push_back(16'h0);
    end else begin
      if (cmd_valid && cmd_mode != 2'b00) begin
        m_strict = (cmd_mode == 2'b11);
        m_has_l = 0; m_pairs.delete(); m_prep = 0; m_dir = 0;
        if (cmd_mode == 2'b01) m_state = 3;
        else if (!m_warm) begin m_state = 1; m_warm = 1; end
        else m_state = 2;
      end else if (cmd_valid && cmd_encode && m_state != 0) begin
        nc = 1; m_state = 0;
      end else if (cmd_valid && !cmd_encode) begin
        m_state = 0;
      end else if (smp_valid && !cmd_valid && m_state != 0) begin
        if (m_state == 1) begin
          m_prep++;
          if (m_prep == PREP_N) m_state = 2;
        end else if (m_state == 3) begin
          m_dir++;
          if (m_dir == DIRECT_N) begin nc = 1; m_state = 0; end
        end else if (!smp_right) begin
          m_l = smp_word; m_has_l = 1;
        end else if (m_has_l) begin
          m_has_l = 0;
          m_pairs.push_back({m_l, smp_word});
          if (m_pairs.size() > 3) void'(m_pairs.pop_front());
          if (m_pairs.size() == 3 && accepts()) begin nc = 1; m_state = 0; end
        end
      end
      if (cap_valid) begin
        m_ref.push_back(cap_word);
        void'(m_ref.pop_front());
      end
    end
    exp_conn = nc;
    exp_busy = (m_state != 0);
  endtask

  always @(posedge clk) begin
    model_step();
    #(CLK_T/4);
    if (rst_n && !done) begin
      check(cur_req, "busy", busy, exp_busy);
      check(cur_req, "connect", connect, exp_conn);
    end
    if (connect) conn_seen++;
  end

  // ---------------- stimulus ----------------
  task automatic go(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(logic [1:0] m, logic e);
    cmd_valid = 1; cmd_mode = m; cmd_encode = e;
    @(negedge clk);
    cmd_valid = 0; cmd_encode = 0;
  endtask

  task automatic feed(logic r, logic [15:0] w);
    smp_valid = 1; smp_right = r; smp_word = w;
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic feed_pair(logic [15:0] l, logic [15:0] r);
    feed(0, l);
    feed(1, r);
  endtask

  task automatic grab(logic [15:0] w);
    cap_valid = 1; cap_word = w;
    @(negedge clk);
    cap_valid = 0;
  endtask

  function automatic logic [15:0] rv(int i);
    return 16'((i + 1) << 12);
  endfunction

  task automatic feed_ref(logic [15:0] add);
    for (int i = 0; i < 3; i++) feed_pair(rv(2*i) | add, rv(2*i+1) | add);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  int mark;

  initial begin
    go(2);
    check("R12", "busy in reset", busy, 0);
    check("R12", "connect in reset", connect, 0);
    rst_n = 1;
    go(1);
    check("R12", "busy after reset", busy, 0);
    for (int i = 0; i < 6; i++) grab(rv(i));

    // R6 / R1: first strict start waits 5 words; leftover right word is dropped (R7)
    cur_req = "R6"; mark = conn_seen;
    issue(2'b11, 0);
    check("R1", "busy after strict start", busy, 1);
    for (int i = 0; i < 6; i++) feed(1'(i % 2), rv(i));
    check("R6", "no connect through preparation", conn_seen - mark, 0);
    feed_ref(16'h0);
    check("R2", "strict match after preparation", conn_seen - mark, 1);
    check("R10", "busy after connect", busy, 0);

    // R6: second start has no preparation
    mark = conn_seen;
    issue(2'b11, 0);
    feed_ref(16'h0);
    check("R6", "restart skips preparation", conn_seen - mark, 1);

    // R2: one bad pair blocks, sliding window then matches
    cur_req = "R2"; mark = conn_seen;
    issue(2'b11, 0);
    feed_pair(rv(0), rv(1)); feed_pair(rv(2), 16'h4001); feed_pair(rv(4), rv(5));
    check("R2", "strict rejects one bad pair", conn_seen - mark, 0);
    feed_ref(16'h0);
    check("R2", "strict sliding match", conn_seen - mark, 1);

    // R3: majority
    cur_req = "R3"; mark = conn_seen;
    issue(2'b10, 0);
    feed_pair(16'h0BAD, 16'h0BAD); feed_pair(16'h0EEE, 16'h0EEE); feed_pair(rv(4), rv(5));
    check("R3", "one of three does not connect", conn_seen - mark, 0);
    feed_pair(rv(0), rv(1)); feed_pair(16'h0EEE, rv(3)); feed_pair(rv(4), rv(5));
    check("R3", "two of three connects", conn_seen - mark, 1);

    // R5: coarse compare changes mid-run
    cur_req = "R5"; mark = conn_seen;
    issue(2'b11, 0);
    feed_ref(16'h0005);
    check("R5", "low bits matter when fine", conn_seen - mark, 0);
    feed_pair(rv(0) | 16'h5, rv(1) | 16'h5); feed_pair(rv(2) | 16'h5, rv(3) | 16'h5);
    coarse_cmp = 1;
    feed_pair(rv(4) | 16'h5, rv(5) | 16'h5);
    check("R5", "coarse compare takes effect at once", conn_seen - mark, 1);
    coarse_cmp = 0;

    // R4: direct mode
    cur_req = "R4"; mark = conn_seen;
    issue(2'b01, 0);
    feed(1, 16'h0123); go(2); feed(0, 16'h0456);
    check("R4", "no connect after two words", conn_seen - mark, 0);
    feed(1, 16'h0789);
    check("R4", "connect after third word", conn_seen - mark, 1);

    // R8: stop
    cur_req = "R8"; mark = conn_seen;
    issue(2'b11, 0);
    feed_pair(rv(0), rv(1));
    issue(2'b00, 0);
    check("R8", "stop clears busy", busy, 0);
    issue(2'b00, 0);
    go(1);
    check("R8", "stop idle quiet", conn_seen - mark, 0);

    // R9: encode request
    cur_req = "R9"; mark = conn_seen;
    issue(2'b11, 1);
    check("R9", "encode with start still searches", busy, 1);
    check("R9", "encode with start no connect", conn_seen - mark, 0);
    issue(2'b00, 1);
    check("R9", "encode while busy connects", conn_seen - mark, 1);
    issue(2'b00, 1);
    go(1);
    check("R9", "encode while idle quiet", conn_seen - mark, 1);

    // R7: stray right word before the first left
    cur_req = "R7"; mark = conn_seen;
    issue(2'b11, 0);
    feed(1, rv(0));
    feed(0, 16'h0DDD);
    feed_ref(16'h0);
    check("R7", "alignment to left word", conn_seen - mark, 1);

    // R11: restart with the final matching word in the same cycle
    cur_req = "R11"; mark = conn_seen;
    issue(2'b11, 0);
    feed_pair(rv(0), rv(1)); feed_pair(rv(2), rv(3)); feed(0, rv(4));
    cmd_valid = 1; cmd_mode = 2'b11; smp_valid = 1; smp_right = 1; smp_word = rv(5);
    @(negedge clk);
    cmd_valid = 0; smp_valid = 0;
    check("R11", "word dropped on command", conn_seen - mark, 0);
    feed_ref(16'h0);
    check("R11", "search after restart", conn_seen - mark, 1);

    // R10: reload the reference and collide a capture with an evaluation
    cur_req = "R10"; mark = conn_seen;
    for (int i = 0; i < 6; i++) grab(16'h7000 + 16'(i * 16'h10));
    issue(2'b11, 0);
    feed_ref(16'h0);
    check("R10", "old reference rejected", conn_seen - mark, 0);
    for (int i = 0; i < 5; i++) feed(1'(i % 2), 16'h7000 + 16'(i * 16'h10));
    cap_valid = 1; cap_word = 16'h0F0F;
    smp_valid = 1; smp_right = 1; smp_word = 16'h7050;
    @(negedge clk);
    cap_valid = 0; smp_valid = 0;
    check("R10", "capture applies after evaluation", conn_seen - mark, 1);
    go(1);
    check("R10", "pulse single", connect, 0);

    go(2);
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog: actual %0d expected %0d cycles", WATCHDOG, WATCHDOG - 1);
      finish_run();
    end
  end

endmodule